// File: doc/BRIEF.md
# Streaming Top-K Distance Selector

This block sits behind a distance engine and keeps the interesting part of one query's result stream. The engine streams (distance, target ID) pairs into a valid/ready port, marking the final pair with a last flag. Depending on configuration, the selector keeps the K nearest pairs, the K farthest pairs, or every pair whose distance does not exceed a threshold. When the last pair has been absorbed, it streams the retained pairs out through a valid/ready port in sorted order, each distance travelling with its ID.

Storage is a sorted list of `DEPTH` entries, sized by parameter (up to 1024 for K near 1000). Each accepted pair is inserted into the list in a single cycle, so the input never stalls while a query is being collected. The output drains the list from its head. A count output reports how many pairs were kept. An overflow flag reports a threshold query in which more pairs qualified than the list could hold. Configuration is sampled once per query, on its first input beat.

Top module: `topk_select`

## Requirements
- R1: With radius mode off (`cfg_radius_i`=0) and direction set to nearest (`cfg_largest_i`=0), the output is the min(K, DEPTH, N) smallest distances of the N received pairs, in non-decreasing distance order, each with the ID it arrived with.
- R2: With `cfg_largest_i`=1 in count mode, the output is the K largest distances, in non-increasing order, each with its ID.
- R3: A new pair displaces a retained one only when its distance is strictly better. Among equal distances the earlier arrival is kept and is output first.
- R4: With `cfg_radius_i`=1, every pair with distance less than or equal to `cfg_thr_i` is kept and the rest are dropped. The output order follows `cfg_largest_i` exactly as in R1 and R2.
- R5: In radius mode, if more than DEPTH pairs qualify, `overflow_o` goes high and the DEPTH best qualifying pairs are kept. The flag stays low for a query where no more than DEPTH qualify.
- R6: When fewer pairs arrive than would fill the list, only the received pairs are output. `count_o` equals the number of retained pairs from the cycle after the last input beat is accepted, and `out_last_o` marks the final output beat.
- R7: `in_ready_o` is low from the cycle after the last input beat until the final output beat is taken, and high in the cycle after that. `out_valid_o` and `in_ready_o` are never high together.
- R8: A K larger than DEPTH is treated as DEPTH. K=0 keeps nothing: no output beat, and `count_o`=0.
- R9: Configuration is sampled on the first input beat of a query. Changing it later in the same query has no effect on the result.
- R10: While `out_valid_o` is high and `out_ready_i` is low, the output distance, ID and last flag hold their values.
- R11: After reset `in_ready_o` is high, `out_valid_o` low, `count_o` zero and `overflow_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_k_i | input | CNT_W | Number of pairs to keep in count mode |
| cfg_thr_i | input | DIST_W | Inclusive distance limit in radius mode |
| cfg_radius_i | input | 1 | 1 selects radius mode, 0 count mode |
| cfg_largest_i | input | 1 | 1 keeps the largest distances and sorts descending |
| in_valid_i | input | 1 | Input pair valid |
| in_ready_o | output | 1 | Selector accepts a pair |
| in_dist_i | input | DIST_W | Input distance |
| in_id_i | input | ID_W | Input target ID |
| in_last_i | input | 1 | Final pair of the query |
| out_valid_o | output | 1 | Retained pair on output |
| out_ready_i | input | 1 | Consumer takes the pair |
| out_dist_o | output | DIST_W | Output distance |
| out_id_o | output | ID_W | Output target ID |
| out_last_o | output | 1 | Final retained pair |
| count_o | output | CNT_W | Number of pairs retained by the latest query |
| overflow_o | output | 1 | Radius query had more qualifying pairs than storage |

## Verification
Each input beat is absorbed at the clock edge where it is taken. The count, the overflow flag and the first output beat therefore all appear in the cycle just after the last input edge, and the bench samples them at the falling edge of that cycle. Output beats are compared by a scoreboard at the falling edge before the handshake edge, so a stalled beat is seen again in the next cycle and is checked for being held. Input ready is expected back exactly one cycle after the edge that takes the final output beat, or after the single empty-result cycle when nothing was kept.

// File: rtl/topk_pkg.sv
package topk_pkg;
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_EMIT    = 1'b1
  } topk_state_e;
endpackage

// File: rtl/topk_cmp.sv
module topk_cmp #(
  parameter int DIST_W = 16
) (
  input  logic [DIST_W-1:0] new_i,
  input  logic [DIST_W-1:0] old_i,
  input  logic              occ_i,
  input  logic              largest_i,
  output logic              better_o
);
  // an empty slot always takes the newcomer; ties never win
  assign better_o = !occ_i || (largest_i ? (new_i > old_i) : (new_i < old_i));
endmodule

// File: rtl/topk_list.sv
module topk_list #(
  parameter int DIST_W = 16,
  parameter int ID_W   = 12,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_i,
  input  logic              pop_i,
  input  logic              largest_i,
  input  logic [CNT_W-1:0]  cap_i,
  input  logic [DIST_W-1:0] dist_i,
  input  logic [ID_W-1:0]   id_i,
  output logic [DIST_W-1:0] head_dist_o,
  output logic [ID_W-1:0]   head_id_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cnt_nxt_o
);
  logic [DIST_W-1:0] dist_q [DEPTH];
  logic [DIST_W-1:0] dist_d [DEPTH];
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [ID_W-1:0]   id_d   [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [DEPTH-1:0]  better;
  logic [CNT_W-1:0]  pos;
  logic              accept;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    topk_cmp #(.DIST_W(DIST_W)) u_cmp (
      .new_i    (dist_i),
      .old_i    (dist_q[g]),
      .occ_i    (CNT_W'(g) < cnt_q),
      .largest_i(largest_i),
      .better_o (better[g])
    );
  end

  // list is sorted, so better[] is a thermometer; pos is its first set bit
  always_comb begin
    pos = CNT_W'(DEPTH);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (better[i]) pos = CNT_W'(i);
    end
  end

  assign accept = ins_i && (pos < cap_i);

  always_comb begin
    dist_d = dist_q;
    id_d   = id_q;
    if (accept) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == pos) begin
          dist_d[i] = dist_i;
          id_d[i]   = id_i;
        end
      end
      for (int i = 1; i < DEPTH; i++) begin
        if (CNT_W'(i) > pos) begin
          dist_d[i] = dist_q[i-1];
          id_d[i]   = id_q[i-1];
        end
      end
    end else if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        dist_d[i] = dist_q[i+1];
        id_d[i]   = id_q[i+1];
      end
    end
  end

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (accept && (cnt_q < cap_i))    cnt_nxt_o = cnt_q + 1'b1;
    else if (pop_i && (cnt_q != '0))  cnt_nxt_o = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    dist_q <= dist_d;
    id_q   <= id_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign head_dist_o = dist_q[0];
  assign head_id_o   = id_q[0];
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/topk_ctrl.sv
module topk_ctrl
  import topk_pkg::*;
#(
  parameter int DIST_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  input  logic [DIST_W-1:0] in_dist_i,
  input  logic [CNT_W-1:0]  cfg_k_i,
  input  logic [DIST_W-1:0] cfg_thr_i,
  input  logic              cfg_radius_i,
  input  logic              cfg_largest_i,
  input  logic              out_ready_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  output logic              ins_o,
  output logic              pop_o,
  output logic              largest_o,
  output logic              radius_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              overflow_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  topk_state_e       state_q;
  logic              first_q;
  logic [CNT_W-1:0]  k_q, k_e;
  logic [DIST_W-1:0] thr_q, thr_e;
  logic              radius_q, largest_q;
  logic [CNT_W-1:0]  total_q;
  logic              ovf_q;
  logic              in_fire, qualify, emit_done;

  // first beat of a query uses live config, later beats the latched copy
  assign k_e       = first_q ? cfg_k_i       : k_q;
  assign thr_e     = first_q ? cfg_thr_i     : thr_q;
  assign radius_o  = first_q ? cfg_radius_i  : radius_q;
  assign largest_o = first_q ? cfg_largest_i : largest_q;

  assign in_ready_o = (state_q == ST_COLLECT);
  assign in_fire    = in_valid_i && in_ready_o;
  assign qualify    = !radius_o || (in_dist_i <= thr_e);
  assign ins_o      = in_fire && qualify;
  assign cap_o      = radius_o ? FULL : ((k_e > FULL) ? FULL : k_e);

  assign out_valid_o = (state_q == ST_EMIT) && (cnt_i != '0);
  assign out_last_o  = out_valid_o && (cnt_i == CNT_W'(1));
  assign pop_o       = out_valid_o && out_ready_i;
  assign emit_done   = (state_q == ST_EMIT) && ((cnt_i == '0) || (pop_o && out_last_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_COLLECT;
      first_q   <= 1'b1;
      k_q       <= '0;
      thr_q     <= '0;
      radius_q  <= 1'b0;
      largest_q <= 1'b0;
      total_q   <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (in_fire) begin
        first_q <= 1'b0;
        ovf_q   <= (ovf_q & ~first_q) | (ins_o & radius_o & (cnt_i == FULL));
        if (first_q) begin
          k_q       <= cfg_k_i;
          thr_q     <= cfg_thr_i;
          radius_q  <= cfg_radius_i;
          largest_q <= cfg_largest_i;
        end
        if (in_last_i) begin
          state_q <= ST_EMIT;
          total_q <= cnt_nxt_i;
        end
      end
      if (emit_done) begin
        state_q <= ST_COLLECT;
        first_q <= 1'b1;
      end
    end
  end

  assign count_o    = total_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/topk_select.sv
module topk_select #(
  parameter int DIST_W = 16,
  parameter int ID_W   = 12,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cfg_k_i,
  input  logic [DIST_W-1:0] cfg_thr_i,
  input  logic              cfg_radius_i,
  input  logic              cfg_largest_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DIST_W-1:0] in_dist_i,
  input  logic [ID_W-1:0]   in_id_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DIST_W-1:0] out_dist_o,
  output logic [ID_W-1:0]   out_id_o,
  output logic              out_last_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              overflow_o
);
  logic             ins, pop, dir_largest, dir_radius;
  logic [CNT_W-1:0] cap, cnt, cnt_nxt;

  topk_ctrl #(.DIST_W(DIST_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_last_i    (in_last_i),
    .in_dist_i    (in_dist_i),
    .cfg_k_i      (cfg_k_i),
    .cfg_thr_i    (cfg_thr_i),
    .cfg_radius_i (cfg_radius_i),
    .cfg_largest_i(cfg_largest_i),
    .out_ready_i  (out_ready_i),
    .cnt_i        (cnt),
    .cnt_nxt_i    (cnt_nxt),
    .in_ready_o   (in_ready_o),
    .out_valid_o  (out_valid_o),
    .out_last_o   (out_last_o),
    .ins_o        (ins),
    .pop_o        (pop),
    .largest_o    (dir_largest),
    .radius_o     (dir_radius),
    .cap_o        (cap),
    .count_o      (count_o),
    .overflow_o   (overflow_o)
  );

  topk_list #(.DIST_W(DIST_W), .ID_W(ID_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_list (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ins_i      (ins),
    .pop_i      (pop),
    .largest_i  (dir_largest),
    .cap_i      (cap),
    .dist_i     (in_dist_i),
    .id_i       (in_id_i),
    .head_dist_o(out_dist_o),
    .head_id_o  (out_id_o),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt)
  );
endmodule

// File: rtl/topk_select_chk.sv
module topk_select_chk #(
  parameter int DIST_W = 16,
  parameter int ID_W   = 12,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DIST_W-1:0] out_dist_o,
  input logic [ID_W-1:0]   out_id_o,
  input logic              out_last_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              dir_largest
);
  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  assert_ready_back_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> in_ready_o);

  assert_ascend_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_last_o && !dir_largest)
      |=> (out_valid_o && (out_dist_o >= $past(out_dist_o))));

  assert_descend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_last_o && dir_largest)
      |=> (out_valid_o && (out_dist_o <= $past(out_dist_o))));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i)
      |=> (out_valid_o && $stable(out_dist_o) && $stable(out_id_o) && $stable(out_last_o)));

  assert_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (count_o != '0));

  assert_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
endmodule

bind topk_select topk_select_chk #(
  .DIST_W(DIST_W), .ID_W(ID_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_dist_o (out_dist_o),
  .out_id_o   (out_id_o),
  .out_last_o (out_last_o),
  .count_o    (count_o),
  .dir_largest(dir_largest)
);

// File: tb/tb_topk_select.sv
`timescale 1ns/1ps
module tb_topk_select;
  localparam int DIST_W = 16;
  localparam int ID_W   = 12;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CNT_W-1:0]  cfg_k = '0;
  logic [DIST_W-1:0] cfg_thr = '0;
  logic              cfg_radius = 1'b0, cfg_largest = 1'b0;
  logic              in_valid = 1'b0, in_last = 1'b0;
  logic [DIST_W-1:0] in_dist = '0;
  logic [ID_W-1:0]   in_id = '0;
  logic              in_ready, out_valid, out_last, overflow;
  logic              out_ready = 1'b1;
  logic [DIST_W-1:0] out_dist;
  logic [ID_W-1:0]   out_id;
  logic [CNT_W-1:0]  count;

  always #2.5 clk = ~clk;

  topk_select #(.DIST_W(DIST_W), .ID_W(ID_W), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_k_i(cfg_k), .cfg_thr_i(cfg_thr), .cfg_radius_i(cfg_radius), .cfg_largest_i(cfg_largest),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_dist_i(in_dist), .in_id_i(in_id),
    .in_last_i(in_last),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_dist_o(out_dist), .out_id_o(out_id),
    .out_last_o(out_last), .count_o(count), .overflow_o(overflow)
  );

  int    n_tests = 0, n_fail = 0;
  int    bd[32], bi[32];
  int    exp_d[$], exp_i[$];
  int    exp_cnt = 0;
  bit    exp_ovf = 1'b0;
  bit    stall_en = 1'b0;
  string cur_req = "R1";
  int    rdy_ctr = 0;
  bit    held_v = 1'b0;
  int    held_d, held_i, held_l;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic fill(int n, int seed);
    for (int j = 0; j < n; j++) begin
      bd[j] = (j * 37 + seed * 13) % 97;
      bi[j] = seed * 32 + j;
    end
  endtask

  // reference: stable insertion by direction, then truncation to capacity
  task automatic build_expected(int n, int k, int thr, bit radius, bit largest);
    int sd[$];
    int si[$];
    int qual = 0;
    int cap;
    for (int j = 0; j < n; j++) begin
      if (!radius || bd[j] <= thr) begin
        int pos = sd.size();
        qual++;
        for (int p = 0; p < sd.size(); p++) begin
          if (largest ? (bd[j] > sd[p]) : (bd[j] < sd[p])) begin
            pos = p;
            break;
          end
        end
        sd.insert(pos, bd[j]);
        si.insert(pos, bi[j]);
      end
    end
    cap = radius ? DEPTH : ((k > DEPTH) ? DEPTH : k);
    exp_cnt = (sd.size() < cap) ? sd.size() : cap;
    for (int p = 0; p < exp_cnt; p++) begin
      exp_d.push_back(sd[p]);
      exp_i.push_back(si[p]);
    end
    exp_ovf = radius && (qual > DEPTH);
  endtask

  task automatic run_query(int n, int k, int thr, bit radius, bit largest, bit scramble, string req);
    build_expected(n, k, thr, radius, largest);
    @(posedge clk); #1;
    cur_req     = req;
    cfg_k       = CNT_W'(k);
    cfg_thr     = DIST_W'(thr);
    cfg_radius  = radius;
    cfg_largest = largest;
    for (int j = 0; j < n; j++) begin
      in_valid = 1'b1;
      in_dist  = DIST_W'(bd[j]);
      in_id    = ID_W'(bi[j]);
      in_last  = (j == n - 1);
      @(posedge clk); #1;
      if (scramble && j == 0) begin
        cfg_k       = ~CNT_W'(k);
        cfg_thr     = ~DIST_W'(thr);
        cfg_radius  = ~radius;
        cfg_largest = ~largest;
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    @(negedge clk);
    check(int'(count) == exp_cnt, "R6", {req, " count_o"}, int'(count), exp_cnt);
    check(overflow == exp_ovf, "R5", {req, " overflow_o"}, int'(overflow), int'(exp_ovf));
    check(in_ready == 1'b0, "R7", {req, " in_ready during emit"}, int'(in_ready), 0);
    while (exp_d.size() > 0) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R7", {req, " in_ready after emit"}, int'(in_ready), 1);
  endtask

  always @(posedge clk) begin
    #1;
    rdy_ctr++;
    out_ready = !stall_en || (rdy_ctr % 3 != 0);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_v) begin
        check(out_valid && int'(out_dist) == held_d && int'(out_id) == held_i &&
              int'(out_last) == held_l, "R10", "held beat changed", int'(out_dist), held_d);
        held_v = 1'b0;
      end
      if (out_valid) begin
        if (!out_ready) begin
          held_v = 1'b1;
          held_d = int'(out_dist);
          held_i = int'(out_id);
          held_l = int'(out_last);
        end else if (exp_d.size() == 0) begin
          check(1'b0, cur_req, "unexpected output beat", int'(out_dist), -1);
        end else begin
          int ed, ei;
          ed = exp_d.pop_front();
          ei = exp_i.pop_front();
          check(int'(out_dist) == ed, cur_req, "out_dist_o", int'(out_dist), ed);
          check(int'(out_id) == ei, cur_req, "out_id_o", int'(out_id), ei);
          check(int'(out_last) == int'(exp_d.size() == 0), "R6", "out_last_o",
                int'(out_last), int'(exp_d.size() == 0));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R11", "in_ready_o after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R11", "out_valid_o after reset", int'(out_valid), 0);
    check(count == '0, "R11", "count_o after reset", int'(count), 0);
    check(overflow == 1'b0, "R11", "overflow_o after reset", int'(overflow), 0);

    fill(10, 1);  run_query(10, 4, 0, 0, 0, 0, "R1");
    fill(10, 2);  run_query(10, 3, 0, 0, 1, 0, "R2");
    fill(20, 3);  run_query(20, 8, 0, 0, 0, 0, "R1");

    // ties: distances 20,5,20,5,30,5
    bd[0] = 20; bd[1] = 5; bd[2] = 20; bd[3] = 5; bd[4] = 30; bd[5] = 5;
    for (int j = 0; j < 6; j++) bi[j] = 100 + j;
    run_query(6, 2, 0, 0, 0, 0, "R3");
    run_query(6, 2, 0, 0, 1, 0, "R3");

    fill(3, 4);   run_query(3, 6, 0, 0, 0, 0, "R6");
    fill(10, 5);  run_query(10, 12, 0, 0, 0, 0, "R8");
    fill(5, 6);   run_query(5, 0, 0, 0, 0, 0, "R8");

    fill(10, 7);  bd[3] = 50; run_query(10, 0, 50, 1, 0, 0, "R4");
    fill(10, 8);  bd[2] = 50; run_query(10, 0, 50, 1, 1, 0, "R4");

    for (int j = 0; j < 12; j++) begin bd[j] = (j * 7) % 40; bi[j] = 200 + j; end
    run_query(12, 0, 100, 1, 0, 0, "R5");
    fill(10, 9);  run_query(10, 0, 30, 1, 0, 0, "R5");

    fill(10, 10); run_query(10, 3, 0, 0, 0, 1, "R9");
    fill(10, 11); run_query(10, 0, 60, 1, 1, 1, "R9");

    stall_en = 1'b1;
    fill(12, 12); run_query(12, 6, 0, 0, 1, 0, "R10");
    fill(12, 13); run_query(12, 0, 70, 1, 0, 0, "R10");
    stall_en = 1'b0;

    fill(1, 14);  run_query(1, 4, 0, 0, 0, 0, "R6");

    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule